// File: doc/BRIEF.md
# Fixed-Latency Memory Request Port

This block sits between the microcoded datapath controller and a memory that always answers in one cycle. Each cycle the controller raises any of three request strobes: data read, data write and instruction fetch. A data access uses the word address held in the memory address register and moves a full word between memory and the memory data register. An instruction fetch uses the byte-granular program counter, reads the containing word and loads the selected byte into the single-byte instruction byte register.

Timing is fixed with no exceptions. A request raised in cycle N is registered at the end of N. The memory works during N+1. The result lands in the destination register at the end of N+1, and the datapath may use it from N+2 onward. A one-cycle valid pulse marks that first usable cycle. Memory never stalls, so the port has no wait or retry path. A read and a fetch may be in flight together because they fill different registers. A read and a write raised together are contradictory. In that case the port drops both and raises an error flag.

Top module: `memreq_port`

## Requirements
- R1: After reset, `mdr_q`, `mbr_q`, both valid flags, `mem_rd`, `mem_wr`, `mem_fetch` and `proto_err` are all zero.
- R2: A read strobe in cycle N (with no write strobe) drives `mem_rd` high in N+1 only, with `mem_addr` equal to the low `WADDR_W` bits of `mar` sampled in N.
- R3: The word that memory returns in N+1 is in `mdr_q` from N+2. During N+1, `mdr_q` still shows its earlier value.
- R4: `mdr_valid` (or `mbr_valid`) is high for exactly one cycle, N+2, after a read (or fetch) issued in N. It is low in every cycle not preceded by a capture.
- R5: A write strobe in cycle N (with no read strobe) drives `mem_wr` in N+1, with `mem_addr` from `mar` and `mem_wdata` equal to the `mdr_q` value held in N. Memory holds the word after the end of N+1.
- R6: A fetch strobe in N drives `mem_fetch` in N+1 with `mem_faddr` = `pc` shifted right by 2. The byte chosen by `pc[1:0]` is loaded into `mbr_q` at the end of N+1. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R7: A read and a fetch raised in the same cycle both complete independently, each into its own register.
- R8: Read and write strobes raised in the same cycle set `proto_err` for one cycle in N+1. Neither `mem_rd` nor `mem_wr` is issued, memory and `mdr_q` are left unchanged, and a fetch raised in that cycle still completes.
- R9: When a datapath write of MDR or MBR falls in the same cycle as a memory capture into that register, the memory value wins.
- R10: A datapath write of MDR or MBR with no capture pending appears in the register the next cycle and raises no valid pulse.
- R11: Reads issued in consecutive cycles each complete, giving valid pulses in consecutive cycles with the data in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Data read strobe from the microword |
| req_wr | input | 1 | Data write strobe from the microword |
| req_fetch | input | 1 | Instruction fetch strobe from the microword |
| mar | input | DATA_W | Word address for data accesses |
| pc | input | DATA_W | Byte address for instruction fetches |
| mdr_we | input | 1 | Datapath write enable for MDR |
| mdr_d | input | DATA_W | Datapath value for MDR |
| mbr_we | input | 1 | Datapath write enable for MBR |
| mbr_d | input | 8 | Datapath value for MBR |
| mem_rd | output | 1 | Data read access in progress |
| mem_wr | output | 1 | Data write access in progress |
| mem_addr | output | WADDR_W | Data word address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory, valid while mem_rd |
| mem_fetch | output | 1 | Instruction fetch access in progress |
| mem_faddr | output | WADDR_W | Fetch word address to memory |
| mem_fdata | input | DATA_W | Fetch word from memory, valid while mem_fetch |
| mdr_q | output | DATA_W | Memory data register |
| mbr_q | output | 8 | Instruction byte register |
| mdr_valid | output | 1 | MDR freshly loaded from memory this cycle |
| mbr_valid | output | 1 | MBR freshly loaded from memory this cycle |
| proto_err | output | 1 | Read and write were requested together |

## Verification
If the request stage holds a wrong value, it shows on the memory strobes and addresses one cycle after the request. The bench checks the strobes and addresses at that point. If a capture register is wrong, it shows in `mdr_q` or `mbr_q` and in the valid flags at N+2. Checks made at N+1 confirm that nothing changes early. A lost override priority or a leaked conflicting write stays hidden until a later read returns the old or the new word. For that reason each such case ends with a read-back.

// File: rtl/memreq_pkg.sv
package memreq_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic fetch;
  } mem_op_t;
endpackage

// File: rtl/memreq_issue.sv
module memreq_issue import memreq_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 16,
  parameter int LANE_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  mem_op_t            op,
  input  logic [WADDR_W-1:0] word_addr,
  input  logic [WADDR_W+LANE_W-1:0] byte_addr,
  input  logic [DATA_W-1:0]  mdr_cur,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_fetch,
  output logic [WADDR_W-1:0] mem_faddr,
  output logic [LANE_W-1:0]  fetch_lane,
  output logic               proto_err
);
  logic clash;
  assign clash = op.rd & op.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_fetch  <= 1'b0;
      proto_err  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_faddr  <= '0;
      fetch_lane <= '0;
    end else begin
      mem_rd    <= op.rd & ~clash;
      mem_wr    <= op.wr & ~clash;
      mem_fetch <= op.fetch;
      proto_err <= clash;
      if ((op.rd | op.wr) && !clash) mem_addr <= word_addr;
      if (op.wr && !clash) mem_wdata <= mdr_cur;
      if (op.fetch) begin
        mem_faddr  <= byte_addr[WADDR_W+LANE_W-1:LANE_W];
        fetch_lane <= byte_addr[LANE_W-1:0];
      end
    end
  end

  AST_RD_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (op.rd && !op.wr) |=> (mem_rd && mem_addr == $past(word_addr))); // R2
  AST_WR_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (op.wr && !op.rd) |=> (mem_wr && mem_wdata == $past(mdr_cur))); // R5
  AST_CLASH_DROP: assert property (@(posedge clk) disable iff (rst)
    (op.rd && op.wr) |=> (proto_err && !mem_rd && !mem_wr)); // R8
  AST_FETCH_ISSUE: assert property (@(posedge clk) disable iff (rst)
    op.fetch |=> (mem_fetch && fetch_lane == $past(byte_addr[LANE_W-1:0]))); // R6
endmodule

// File: rtl/byte_lane_sel.sv
module byte_lane_sel #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  output logic [BYTE_W-1:0] sel
);
  logic [BYTE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign sel = lanes[lane];
endmodule

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_d,
  input  logic         dp_we,
  input  logic [W-1:0] dp_d,
  output logic [W-1:0] q,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= cap;
      if (cap)        q <= cap_d;
      else if (dp_we) q <= dp_d;
    end
  end

  AST_CAP_WINS: assert property (@(posedge clk) disable iff (rst)
    cap |=> (valid && q == $past(cap_d))); // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    !cap |=> !valid); // R4
endmodule

// File: rtl/memreq_port.sv
module memreq_port import memreq_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int WADDR_W = 16,
  parameter int BYTE_W  = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic               req_fetch,
  input  logic [DATA_W-1:0]  mar,
  input  logic [DATA_W-1:0]  pc,
  input  logic               mdr_we,
  input  logic [DATA_W-1:0]  mdr_d,
  input  logic               mbr_we,
  input  logic [BYTE_W-1:0]  mbr_d,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_fetch,
  output logic [WADDR_W-1:0] mem_faddr,
  input  logic [DATA_W-1:0]  mem_fdata,
  output logic [DATA_W-1:0]  mdr_q,
  output logic [BYTE_W-1:0]  mbr_q,
  output logic               mdr_valid,
  output logic               mbr_valid,
  output logic               proto_err
);
  mem_op_t            op;
  logic [LANE_W-1:0]  lane;
  logic [BYTE_W-1:0]  fbyte;
  logic               unused_hi;

  assign op        = '{rd: req_rd, wr: req_wr, fetch: req_fetch};
  assign unused_hi = ^{mar[DATA_W-1:WADDR_W], pc[DATA_W-1:WADDR_W+LANE_W]};

  memreq_issue #(.DATA_W(DATA_W), .WADDR_W(WADDR_W), .LANE_W(LANE_W)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .word_addr  (mar[WADDR_W-1:0]),
    .byte_addr  (pc[WADDR_W+LANE_W-1:0]),
    .mdr_cur    (mdr_q),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_fetch  (mem_fetch),
    .mem_faddr  (mem_faddr),
    .fetch_lane (lane),
    .proto_err  (proto_err)
  );

  byte_lane_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .word (mem_fdata),
    .lane (lane),
    .sel  (fbyte)
  );

  capture_reg #(.W(DATA_W)) u_mdr (
    .clk   (clk),
    .rst   (rst),
    .cap   (mem_rd),
    .cap_d (mem_rdata),
    .dp_we (mdr_we),
    .dp_d  (mdr_d),
    .q     (mdr_q),
    .valid (mdr_valid)
  );

  capture_reg #(.W(BYTE_W)) u_mbr (
    .clk   (clk),
    .rst   (rst),
    .cap   (mem_fetch),
    .cap_d (fbyte),
    .dp_we (mbr_we),
    .dp_d  (mbr_d),
    .q     (mbr_q),
    .valid (mbr_valid)
  );

  AST_READ_FETCH_INDEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_fetch) |=> (mdr_valid && mbr_valid)); // R7
endmodule

// File: tb/sim_memreq_port.sv
`timescale 1ns/1ps
module sim_memreq_port;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int VW = 56;
  localparam int NV = 5;
  // {rd, fetch, mar[5:0], pc[7:0], exp_mdr[31:0], exp_mbr[7:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd5,  8'h00, 32'hC5854505, 8'h00},
    {1'b0, 1'b1, 6'd0,  8'h0B, 32'h00000000, 8'hC2},
    {1'b1, 1'b1, 6'h10, 8'h21, 32'hD0905010, 8'h48},
    {1'b1, 1'b0, 6'h3F, 8'h00, 32'hFFBF7F3F, 8'h00},
    {1'b0, 1'b1, 6'd0,  8'hFC, 32'h00000000, 8'h3F}
  };

  logic clk = 0, rst = 1;
  logic req_rd = 0, req_wr = 0, req_fetch = 0;
  logic [DW-1:0] mar = 0, pc = 0, mdr_d = 0;
  logic mdr_we = 0, mbr_we = 0;
  logic [7:0] mbr_d = 0;
  logic mem_rd, mem_wr, mem_fetch, mdr_valid, mbr_valid, proto_err;
  logic [AW-1:0] mem_addr, mem_faddr;
  logic [DW-1:0] mem_wdata, mem_rdata, mem_fdata, mdr_q;
  logic [7:0] mbr_q;
  logic [DW-1:0] mem [64];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] wval(int i);
    logic [7:0] b = 8'(i);
    return {b + 8'hC0, b + 8'h80, b + 8'h40, b};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= wval(i);
    end else if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[5:0]];
  assign mem_fdata = mem[mem_faddr[5:0]];

  memreq_port u0 (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_fetch(req_fetch),
    .mar(mar), .pc(pc), .mdr_we(mdr_we), .mdr_d(mdr_d), .mbr_we(mbr_we), .mbr_d(mbr_d),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_fetch(mem_fetch), .mem_faddr(mem_faddr),
    .mem_fdata(mem_fdata), .mdr_q(mdr_q), .mbr_q(mbr_q), .mdr_valid(mdr_valid),
    .mbr_valid(mbr_valid), .proto_err(proto_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    tick(); rst = 0;
    // R1 reset state
    chk("R1", "mdr_q", mdr_q, 0);
    chk("R1", "mbr_q", 32'(mbr_q), 0);
    chk("R1", "valids", {30'd0, mdr_valid, mbr_valid}, 0);
    chk("R1", "strobes", {28'd0, mem_rd, mem_wr, mem_fetch, proto_err}, 0);

    // vector table: R2 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e = VEC[v];
      logic vr = e[55], vf = e[54];
      req_rd = vr; req_fetch = vf; mar = 32'(e[53:48]); pc = 32'(e[47:40]);
      tick(); req_rd = 0; req_fetch = 0;
      chk("R2", "mem_rd", 32'(mem_rd), 32'(vr));
      if (vr) chk("R2", "mem_addr", 32'(mem_addr), 32'(e[53:48]));
      chk("R6", "mem_fetch", 32'(mem_fetch), 32'(vf));
      if (vf) chk("R6", "mem_faddr", 32'(mem_faddr), 32'(e[47:42]));
      chk("R4", "valid early", {30'd0, mdr_valid, mbr_valid}, 0);
      tick();
      if (vr) begin
        chk("R3", "mdr_q", mdr_q, e[39:8]);
        chk("R4", "mdr_valid", 32'(mdr_valid), 1);
      end
      if (vf) begin
        chk("R6", "mbr_q", 32'(mbr_q), 32'(e[7:0]));
        chk("R4", "mbr_valid", 32'(mbr_valid), 1);
      end
      if (vr && vf) chk("R7", "both valid", {30'd0, mdr_valid, mbr_valid}, 3);
    end
    tick();

    // R10 then R5 write path
    mdr_we = 1; mdr_d = 32'hDEADBEEF;
    tick(); mdr_we = 0;
    chk("R10", "mdr_q dp", mdr_q, 32'hDEADBEEF);
    chk("R10", "mdr_valid", 32'(mdr_valid), 0);
    req_wr = 1; mar = 7;
    tick(); req_wr = 0;
    chk("R5", "mem_wr", {30'd0, mem_wr, mem_rd}, 2);
    chk("R5", "mem_addr", 32'(mem_addr), 7);
    chk("R5", "mem_wdata", mem_wdata, 32'hDEADBEEF);
    tick(); mdr_we = 1; mdr_d = 0;
    tick(); mdr_we = 0; req_rd = 1; mar = 7;
    chk("R3", "mdr_q before", mdr_q, 0);
    tick(); req_rd = 0;
    chk("R3", "mdr_q held in N+1", mdr_q, 0);
    tick();
    chk("R5", "readback", mdr_q, 32'hDEADBEEF);

    // R9 capture overrides datapath write
    req_rd = 1; mar = 9;
    tick(); req_rd = 0; mdr_we = 1; mdr_d = 32'h12345678;
    tick(); mdr_we = 0;
    chk("R9", "mdr override", mdr_q, wval(9));
    req_fetch = 1; pc = 32'h06;
    tick(); req_fetch = 0; mbr_we = 1; mbr_d = 8'h5A;
    tick(); mbr_we = 0;
    chk("R9", "mbr override", 32'(mbr_q), 32'h81);
    mbr_we = 1; mbr_d = 8'h77;
    tick(); mbr_we = 0;
    chk("R10", "mbr dp", 32'(mbr_q), 32'h77);
    chk("R10", "mbr_valid", 32'(mbr_valid), 0);

    // R8 read+write clash, fetch alongside
    req_rd = 1; req_wr = 1; req_fetch = 1; mar = 4; pc = 32'h0D;
    tick(); req_rd = 0; req_wr = 0; req_fetch = 0;
    chk("R8", "err/rd/wr/fetch", {28'd0, proto_err, mem_rd, mem_wr, mem_fetch}, 32'b1001);
    tick();
    chk("R8", "err pulse", 32'(proto_err), 0);
    chk("R8", "mdr kept", mdr_q, wval(9));
    chk("R8", "mdr_valid", 32'(mdr_valid), 0);
    chk("R8", "fetch done", {23'd0, mbr_valid, mbr_q}, 32'h143);
    req_rd = 1; mar = 4;
    tick(); req_rd = 0;
    tick();
    chk("R8", "memory kept", mdr_q, wval(4));

    // R11 back-to-back reads
    req_rd = 1; mar = 1;
    tick(); mar = 2;
    chk("R11", "addr 1", 32'(mem_addr), 1);
    tick(); req_rd = 0;
    chk("R11", "addr 2", 32'(mem_addr), 2);
    chk("R11", "first data", {31'd0, mdr_valid}, 1);
    chk("R11", "first word", mdr_q, wval(1));
    tick();
    chk("R11", "second data", {31'd0, mdr_valid}, 1);
    chk("R11", "second word", mdr_q, wval(2));
    tick();
    chk("R4", "pulse ends", 32'(mdr_valid), 0);

    finish_run();
  end
endmodule